// File: doc/BRIEF.md
# Single-Level Paged Address Translator

This block maps a 16-bit virtual address onto a 15-bit physical address. It uses a page table of sixteen entries held in registers, with one entry for each 4 KB page. The upper four bits of the virtual address select an entry. That entry's frame number takes the place of those bits, and the low twelve bits pass through unchanged. The lookup is combinational from the registered table, so a request presented in a cycle is answered in that same cycle.

Each entry holds the following fields:
- a 3-bit frame number;
- a present flag;
- a read-permit flag;
- a write-permit flag;
- a referenced flag;
- a modified flag;
- a no-cache attribute.

A lookup that succeeds updates the referenced and modified flags of its page at the next clock edge. A lookup to a page that is not resident raises a page-fault flag. A lookup whose access kind is not permitted raises a protection-fault flag. Software loads whole entries through a write port, clears every referenced flag with a single strobe, and reads any entry back through a read port.

Top module: `pgx_xlat`

## Requirements
- R1: For a valid lookup that succeeds, the physical address is the 3-bit frame number of the entry selected by `vaddr[15:12]`, placed above `vaddr[11:0]`. For example, page 0 in frame 2 maps virtual 0 to physical 8192, and page 5 in frame 3 maps virtual 20500 to physical 12308.
- R2: If the selected entry's present flag (bit 3) is 0, a valid lookup raises the page-fault flag and drives both the physical address and the no-cache output to 0.
- R3: A present page raises the protection-fault flag when a read finds the read-permit flag (bit 4) at 0, or when a write finds the write-permit flag (bit 5) at 0. In that case the physical address is 0.
- R4: The two fault flags are never high together. For a non-present page, only the page-fault flag rises, whatever the permit flags hold.
- R5: A lookup that succeeds sets the referenced flag (bit 6) of its entry at the next clock edge.
- R6: A write lookup that succeeds also sets the modified flag (bit 7). A read lookup leaves the modified flag unchanged.
- R7: A lookup that faults leaves every entry unchanged.
- R8: A lookup that succeeds drives the no-cache output from the entry's bit 8.
- R9: A software write replaces the whole 9-bit entry at `sw_idx_i` at the next clock edge. The entry layout is frame[2:0], present[3], read-permit[4], write-permit[5], referenced[6], modified[7], no-cache[8]. If a status update targets the same entry in the same cycle, the software write wins.
- R10: The clear strobe zeroes every referenced flag at the next clock edge. A lookup that succeeds in the same cycle still leaves its own page's referenced flag set.
- R11: After reset every entry is 0, so every valid lookup raises a page fault.
- R12: When `lk_valid_i` is low, all lookup outputs are 0 and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 16 | Virtual address |
| lk_write_i | input | 1 | 1 = write access, 0 = read access |
| lk_paddr_o | output | 15 | Physical address; 0 unless the lookup succeeds |
| lk_pfault_o | output | 1 | Page not present |
| lk_prot_o | output | 1 | Access kind not permitted |
| lk_nocache_o | output | 1 | No-cache attribute of the translated page |
| sw_we_i | input | 1 | Entry write strobe |
| sw_idx_i | input | 4 | Entry written |
| sw_pte_i | input | 9 | Entry value written |
| sw_clr_ref_i | input | 1 | Clear every referenced flag |
| sw_rd_idx_i | input | 4 | Entry read back |
| sw_rd_pte_o | output | 9 | Current value of the entry read back |

## Verification
The bench targets the collisions within a single cycle. In the first, a software load meets a status update to the same page; if the update wins, the freshly loaded entry picks up stray referenced and modified bits. In the second, the clear strobe meets a successful lookup; if the clear is applied last, the touched page loses its referenced flag. Faulting lookups are followed by read-back of the target entry, which catches a design that marks pages it refused to translate. A non-present page with no permissions is looked up with a write, which catches a design that raises both fault flags together or drops the page-fault priority. Idle cycles with a live address on the bus catch status updates that ignore the valid input.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  parameter int VA_W  = 16;
  parameter int OFS_W = 12;
  parameter int FRM_W = 3;

  localparam int VPN_W = VA_W - OFS_W;
  localparam int NPAGE = 1 << VPN_W;
  localparam int PA_W  = FRM_W + OFS_W;
  localparam int PTE_W = FRM_W + 6;

  typedef struct packed {
    logic             nocache;
    logic             modified;
    logic             referenced;
    logic             wr_ok;
    logic             rd_ok;
    logic             present;
    logic [FRM_W-1:0] frame;
  } pte_t;
endpackage

// File: rtl/pgx_check.sv
module pgx_check
  import pgx_pkg::*;
(
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  pte_t             pte_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic             pfault_o,
  output logic             prot_o,
  output logic             nocache_o,
  output logic             upd_en_o
);
  logic perm;
  logic ok;

  always_comb begin
    perm      = write_i ? pte_i.wr_ok : pte_i.rd_ok;
    pfault_o  = valid_i && !pte_i.present;
    prot_o    = valid_i && pte_i.present && !perm;
    ok        = valid_i && pte_i.present && perm;
    paddr_o   = ok ? {pte_i.frame, ofs_i} : '0;
    nocache_o = ok && pte_i.nocache;
    upd_en_o  = ok;
  end
endmodule

// File: rtl/pgx_table.sv
module pgx_table
  import pgx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output pte_t             lk_pte_o,
  input  logic             upd_en_i,
  input  logic             upd_wr_i,
  input  logic             we_i,
  input  logic [VPN_W-1:0] w_idx_i,
  input  pte_t             w_pte_i,
  input  logic             clr_ref_i,
  input  logic [VPN_W-1:0] rd_idx_i,
  output pte_t             rd_pte_o
);
  pte_t [NPAGE-1:0] ent_q;
  pte_t             ent_d [NPAGE];

  for (genvar g = 0; g < NPAGE; g++) begin : g_ent
    always_comb begin
      ent_d[g] = ent_q[g];
      if (clr_ref_i) ent_d[g].referenced = 1'b0;
      // access is newer than the clear
      if (upd_en_i && lk_vpn_i == VPN_W'(g)) begin
        ent_d[g].referenced = 1'b1;
        if (upd_wr_i) ent_d[g].modified = 1'b1;
      end
      if (we_i && w_idx_i == VPN_W'(g)) ent_d[g] = w_pte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= '0;
    else for (int i = 0; i < NPAGE; i++) ent_q[i] <= ent_d[i];
  end

  assign lk_pte_o = ent_q[lk_vpn_i];
  assign rd_pte_o = ent_q[rd_idx_i];

  p_swload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(w_idx_i)] == $past(w_pte_i));

  p_refset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !(we_i && w_idx_i == lk_vpn_i) |=> ent_q[$past(lk_vpn_i)].referenced);

  p_modset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_wr_i && !(we_i && w_idx_i == lk_vpn_i) |=> ent_q[$past(lk_vpn_i)].modified);

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i && !we_i && !clr_ref_i |=> $stable(ent_q));
endmodule

// File: rtl/pgx_xlat.sv
module pgx_xlat
  import pgx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VA_W-1:0]  lk_vaddr_i,
  input  logic             lk_write_i,
  output logic [PA_W-1:0]  lk_paddr_o,
  output logic             lk_pfault_o,
  output logic             lk_prot_o,
  output logic             lk_nocache_o,
  input  logic             sw_we_i,
  input  logic [VPN_W-1:0] sw_idx_i,
  input  logic [PTE_W-1:0] sw_pte_i,
  input  logic             sw_clr_ref_i,
  input  logic [VPN_W-1:0] sw_rd_idx_i,
  output logic [PTE_W-1:0] sw_rd_pte_o
);
  pte_t lk_pte;
  pte_t rd_pte;
  logic upd_en;

  pgx_table u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_vpn_i  (lk_vaddr_i[VA_W-1:OFS_W]),
    .lk_pte_o  (lk_pte),
    .upd_en_i  (upd_en),
    .upd_wr_i  (lk_write_i),
    .we_i      (sw_we_i),
    .w_idx_i   (sw_idx_i),
    .w_pte_i   (pte_t'(sw_pte_i)),
    .clr_ref_i (sw_clr_ref_i),
    .rd_idx_i  (sw_rd_idx_i),
    .rd_pte_o  (rd_pte)
  );

  pgx_check u_check (
    .valid_i   (lk_valid_i),
    .write_i   (lk_write_i),
    .ofs_i     (lk_vaddr_i[OFS_W-1:0]),
    .pte_i     (lk_pte),
    .paddr_o   (lk_paddr_o),
    .pfault_o  (lk_pfault_o),
    .prot_o    (lk_prot_o),
    .nocache_o (lk_nocache_o),
    .upd_en_o  (upd_en)
  );

  assign sw_rd_pte_o = PTE_W'(rd_pte);

  p_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_pfault_o && lk_prot_o));

  p_offset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en |-> lk_paddr_o[OFS_W-1:0] == lk_vaddr_i[OFS_W-1:0]);

  p_nopa_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_pfault_o |-> lk_paddr_o == '0 && !lk_nocache_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !lk_pfault_o && !lk_prot_o && !upd_en);
endmodule

// File: tb/sim_pgx_xlat.sv
module sim_pgx_xlat;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i = 1'b0;
  logic [15:0] lk_vaddr_i = '0;
  logic        lk_write_i = 1'b0;
  logic [14:0] lk_paddr_o;
  logic        lk_pfault_o, lk_prot_o, lk_nocache_o;
  logic        sw_we_i = 1'b0;
  logic [3:0]  sw_idx_i = '0;
  logic [8:0]  sw_pte_i = '0;
  logic        sw_clr_ref_i = 1'b0;
  logic [3:0]  sw_rd_idx_i = '0;
  logic [8:0]  sw_rd_pte_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [14:0] pa;
    logic        pf, pr, nc;
    logic [8:0]  rd;
    string       tag;
  } item_t;

  item_t      exp_q[$];
  logic [8:0] model [16];

  always #2 clk = ~clk;

  pgx_xlat u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vaddr_i(lk_vaddr_i), .lk_write_i(lk_write_i),
    .lk_paddr_o(lk_paddr_o), .lk_pfault_o(lk_pfault_o), .lk_prot_o(lk_prot_o),
    .lk_nocache_o(lk_nocache_o),
    .sw_we_i(sw_we_i), .sw_idx_i(sw_idx_i), .sw_pte_i(sw_pte_i),
    .sw_clr_ref_i(sw_clr_ref_i), .sw_rd_idx_i(sw_rd_idx_i), .sw_rd_pte_o(sw_rd_pte_o)
  );

  // driver: expected values from the table model, then model update for the coming edge
  task automatic step(input logic v, input logic [15:0] va, input logic wr,
                      input logic we, input logic [3:0] widx, input logic [8:0] wd,
                      input logic clr, input logic [3:0] ridx, input string tag);
    item_t      it;
    logic [8:0] e;
    logic       ok;
    @(negedge clk);
    e     = model[va[15:12]];
    it.pf = v && !e[3];
    it.pr = v && e[3] && !(wr ? e[5] : e[4]);
    ok    = v && e[3] && (wr ? e[5] : e[4]);
    it.pa = ok ? {e[2:0], va[11:0]} : 15'd0;
    it.nc = ok && e[8];
    it.rd = model[ridx];
    it.tag = tag;
    exp_q.push_back(it);
    lk_valid_i = v; lk_vaddr_i = va; lk_write_i = wr;
    sw_we_i = we; sw_idx_i = widx; sw_pte_i = wd;
    sw_clr_ref_i = clr; sw_rd_idx_i = ridx;
    if (clr) for (int i = 0; i < 16; i++) model[i][6] = 1'b0;
    if (ok) begin
      model[va[15:12]][6] = 1'b1;
      if (wr) model[va[15:12]][7] = 1'b1;
    end
    if (we) model[widx] = wd;
  endtask

  task automatic peek(input logic [3:0] ridx, input string tag);
    step(1'b0, 16'h0000, 1'b0, 1'b0, 4'd0, 9'd0, 1'b0, ridx, tag);
  endtask

  task automatic load(input logic [3:0] idx, input logic [8:0] val, input logic [3:0] ridx);
    step(1'b0, 16'h0000, 1'b0, 1'b1, idx, val, 1'b0, ridx, "R9");
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (lk_paddr_o !== it.pa || lk_pfault_o !== it.pf || lk_prot_o !== it.pr ||
          lk_nocache_o !== it.nc || sw_rd_pte_o !== it.rd) begin
        n_bad++;
        $display("FAIL %s: got pa=%h pf=%b pr=%b nc=%b rd=%h, want pa=%h pf=%b pr=%b nc=%b rd=%h",
                 it.tag, lk_paddr_o, lk_pfault_o, lk_prot_o, lk_nocache_o, sw_rd_pte_o,
                 it.pa, it.pf, it.pr, it.nc, it.rd);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11: empty table after reset
    step(1'b1, 16'h0000, 1'b0, 1'b0, 4'd0, 9'd0, 1'b0, 4'd0,  "R11");
    step(1'b1, 16'hF123, 1'b1, 1'b0, 4'd0, 9'd0, 1'b0, 4'd15, "R11");
    // R9: whole-entry loads, read back one cycle later
    load(4'd0, 9'h03A, 4'd0);   // frame 2, present, rd+wr
    load(4'd5, 9'h01B, 4'd0);   // frame 3, present, read only
    load(4'd3, 9'h13F, 4'd5);   // frame 7, rd+wr, no-cache
    load(4'd8, 9'h030, 4'd3);   // not present, rd+wr permits
    // R1: translations
    step(1'b1, 16'd0,     1'b0, 1'b0, 4'd0, 9'd0, 1'b0, 4'd8, "R1");
    step(1'b1, 16'd20500, 1'b0, 1'b0, 4'd0, 9'd0, 1'b0, 4'd0, "R1");
    peek(4'd5, "R5");
    // R3: write to read-only page
    step(1'b1, 16'd20500, 1'b1, 1'b0, 4'd0, 9'd0, 1'b0, 4'd5, "R3");
    peek(4'd5, "R7");
    // R2 / R4: non-present page
    step(1'b1, 16'd32780, 1'b0, 1'b0, 4'd0, 9'd0, 1'b0, 4'd8, "R2");
    load(4'd8, 9'h000, 4'd8);
    step(1'b1, 16'd32780, 1'b1, 1'b0, 4'd0, 9'd0, 1'b0, 4'd8, "R4");
    peek(4'd8, "R7");
    // R6: write sets modified
    step(1'b1, 16'h0ABC, 1'b1, 1'b0, 4'd0, 9'd0, 1'b0, 4'd0, "R6");
    peek(4'd0, "R6");
    // R8: no-cache attribute
    step(1'b1, 16'h3FFF, 1'b0, 1'b0, 4'd0, 9'd0, 1'b0, 4'd3, "R8");
    // R10: clear with same-cycle access to page 5
    step(1'b1, 16'h5010, 1'b0, 1'b0, 4'd0, 9'd0, 1'b1, 4'd0, "R10");
    peek(4'd0, "R10");
    peek(4'd5, "R10");
    peek(4'd3, "R10");
    // R9: software write beats same-cycle status update
    step(1'b1, 16'h0004, 1'b1, 1'b1, 4'd0, 9'h03E, 1'b0, 4'd0, "R9");
    peek(4'd0, "R9");
    // R12: idle cycle with a live address
    step(1'b0, 16'h0004, 1'b1, 1'b0, 4'd0, 9'd0, 1'b0, 4'd0, "R12");
    peek(4'd0, "R12");
    step(1'b1, 16'h0004, 1'b0, 1'b0, 4'd0, 9'd0, 1'b0, 4'd0, "R1");
    peek(4'd0, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule